// File: doc/BRIEF.md
# Endian-Aware Vector Memory Formatter

This block shapes data for one vector load or store micro-operation. A load delivers a stream of up to 16 memory bytes, which the block turns into up to four 32-bit register words. A store delivers register words, which the block turns into memory bytes. For both directions the same byte reorder applies. When the big-endian mode bit is set, every element of the chosen size (1, 2, 4 or 8 bytes) is byte-reversed. Every byte at or past the access length is forced to zero, so the top bytes of the last register word are masked.

In the same operation the block also computes the effective address. The address is the base plus or minus an immediate, chosen by an up flag. When a 64-bit floating-point value is moved as two 32-bit halves, a half selector applies a ±4 word-swap offset, and it does so only in big-endian mode.

The operation is started by a one-cycle strobe. Results are registered and appear one cycle later, together with a done pulse. An illegal request sets an error flag in the done cycle and leaves every result register as it was.

Top module: `vmem_fmt`

## Requirements
- R1: The legal access lengths `size_bytes` are 1, 2, 3, 4, 6, 8, 12 and 16. Any other value (including 0, 5, 7 and 9) makes the request illegal.
- R2: `elem_log2` gives the element size as 2^elem_log2 bytes (0→1, 1→2, 2→4, 3→8). A request whose element size does not divide the access length is illegal.
- R3: `half_sel` is encoded 0 = whole transfer, 1 = half that adds 4, 2 = half that subtracts 4, and 3 = reserved. The reserved code is illegal.
- R4: For an illegal request, `err` and `done` are both high in the cycle after `start`. `reg_out`, `mem_out`, `word_cnt` and `ea` keep their previous values.
- R5: After a legal request, `word_cnt` equals ceil(size_bytes/4).
- R6: Stream byte k sits at bits [8k+7:8k] of `mem_in` and `mem_out`. Register word w sits at bits [32w+31:32w] of `reg_in` and `reg_out`, and byte k of the stream maps to bits [8(k%4)+7:8(k%4)] of word k/4. With `big_endian` = 0, a load copies the bytes in this order.
- R7: With `big_endian` = 1, output byte k takes input byte k XOR (element bytes − 1), so each element is byte-reversed in place.
- R8: Every output byte at index ≥ size_bytes is zero. This includes the masked upper bytes of the last register word.
- R9: With `is_store` = 1, `reg_in` goes through the same reorder and mask (R6–R8) into `mem_out`, and `reg_out` is not changed. With `is_store` = 0, `mem_in` goes into `reg_out`, and `mem_out` is not changed.
- R10: After a legal request, `ea` = base + imm when `up` = 1 and base − imm when `up` = 0. In big-endian mode, 4 is added for `half_sel` = 1 and subtracted for `half_sel` = 2. In little-endian mode no offset is applied.
- R11: `done` is high exactly in the cycle after each `start` cycle and is low otherwise. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| is_store | input | 1 | 1 = store (registers to memory), 0 = load |
| big_endian | input | 1 | Big-endian mode bit |
| elem_log2 | input | 2 | Element size code, bytes = 2^code |
| size_bytes | input | 5 | Access length in bytes |
| half_sel | input | 2 | Split double-word half selector |
| up | input | 1 | 1 = add immediate, 0 = subtract |
| base | input | 32 | Base address |
| imm | input | 32 | Immediate offset |
| mem_in | input | 128 | Memory bytes for a load |
| reg_in | input | 128 | Register words for a store |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Illegal request flag, valid with done |
| word_cnt | output | 3 | Register words touched |
| ea | output | 32 | Effective address |
| reg_out | output | 128 | Register words from a load |
| mem_out | output | 128 | Memory bytes from a store |

## Verification
All state is held in the output registers, so a fault in the next-state logic shows at the ports in the cycle after the `start` that triggers it. A wrong swap index shows up as a byte moved out of place inside one element. A wrong length mask shows up as non-zero bytes above the access length. A wrong direction select leaves the opposite result register changed after the operation. A wrong legality decision appears as an `err` value that disagrees with the request, or as result registers that change when they should hold.

// File: rtl/vmem_fmt_pkg.sv
package vmem_fmt_pkg;
  typedef enum logic [1:0] {
    HALF_NONE = 2'd0,
    HALF_ADD  = 2'd1,
    HALF_SUB  = 2'd2,
    HALF_RSVD = 2'd3
  } half_e;

  localparam int unsigned HALF_OFFSET = 4;
endpackage

// File: rtl/vmem_size_chk.sv
module vmem_size_chk #(
  parameter int unsigned NBYTES = 16,
  localparam int unsigned SW     = $clog2(NBYTES + 1),
  localparam int unsigned NWORDS = (NBYTES + 3) / 4,
  localparam int unsigned WCW    = $clog2(NWORDS + 1)
) (
  input  logic [SW-1:0]  size_i,
  input  logic [1:0]     elem_log2_i,
  input  logic [1:0]     half_i,
  output logic           legal_o,
  output logic [WCW-1:0] words_o
);
  import vmem_fmt_pkg::*;

  logic [SW-1:0] ebytes;
  logic          size_ok;
  logic          elem_ok;
  logic [SW:0]   rounded;

  always_comb begin
    ebytes  = SW'(1) << elem_log2_i;
    size_ok = ((size_i >= SW'(1)) && (size_i <= SW'(4))) ||
              (size_i == SW'(6)) ||
              ((size_i[1:0] == 2'b00) && (size_i != '0) && (size_i <= SW'(NBYTES)));
    elem_ok = (ebytes <= SW'(NBYTES)) && ((size_i & (ebytes - SW'(1))) == '0);
    legal_o = size_ok && elem_ok && (half_e'(half_i) != HALF_RSVD);
    rounded = {1'b0, size_i} + (SW+1)'(3);
    words_o = WCW'(rounded >> 2);
  end

  always_comb begin
    // R5
    if (legal_o) begin
      wordcnt_range_chk: assert (words_o != '0 && words_o <= WCW'(NWORDS));
    end
  end
endmodule

// File: rtl/vmem_swap.sv
module vmem_swap #(
  parameter int unsigned NBYTES = 16,
  localparam int unsigned SW = $clog2(NBYTES + 1),
  localparam int unsigned IW = $clog2(NBYTES),
  localparam int unsigned DW = 8 * NBYTES
) (
  input  logic [DW-1:0] data_i,
  input  logic          big_i,
  input  logic [1:0]    elem_log2_i,
  input  logic [SW-1:0] size_i,
  output logic [DW-1:0] data_o
);
  logic [IW-1:0] emask;

  always_comb begin
    emask = IW'((5'd1 << elem_log2_i) - 5'd1);
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [IW-1:0] src;
    always_comb begin
      src = big_i ? (IW'(i) ^ emask) : IW'(i);
      if (size_i > SW'(i)) begin
        data_o[8*i +: 8] = data_i[8*src +: 8];
      end else begin
        data_o[8*i +: 8] = 8'h00;
      end
    end
  end
endmodule

// File: rtl/vmem_ea.sv
module vmem_ea #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] imm_i,
  input  logic          up_i,
  input  logic          big_i,
  input  logic [1:0]    half_i,
  output logic [AW-1:0] ea_o
);
  import vmem_fmt_pkg::*;

  logic [AW-1:0] plain;
  logic [AW-1:0] adj;

  always_comb begin
    plain = up_i ? (base_i + imm_i) : (base_i - imm_i);
    adj   = '0;
    if (big_i) begin
      unique case (half_e'(half_i))
        HALF_ADD: adj = AW'(HALF_OFFSET);
        HALF_SUB: adj = -AW'(HALF_OFFSET);
        default:  adj = '0;
      endcase
    end
    ea_o = plain + adj;
  end
endmodule

// File: rtl/vmem_fmt.sv
module vmem_fmt #(
  parameter int unsigned NBYTES = 16,
  parameter int unsigned AW     = 32,
  localparam int unsigned SW     = $clog2(NBYTES + 1),
  localparam int unsigned DW     = 8 * NBYTES,
  localparam int unsigned NWORDS = (NBYTES + 3) / 4,
  localparam int unsigned WCW    = $clog2(NWORDS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_store,
  input  logic           big_endian,
  input  logic [1:0]     elem_log2,
  input  logic [SW-1:0]  size_bytes,
  input  logic [1:0]     half_sel,
  input  logic           up,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  imm,
  input  logic [DW-1:0]  mem_in,
  input  logic [DW-1:0]  reg_in,
  output logic           done,
  output logic           err,
  output logic [WCW-1:0] word_cnt,
  output logic [AW-1:0]  ea,
  output logic [DW-1:0]  reg_out,
  output logic [DW-1:0]  mem_out
);
  logic           legal;
  logic [WCW-1:0] words_c;
  logic [DW-1:0]  swap_in;
  logic [DW-1:0]  swap_out;
  logic [AW-1:0]  ea_c;

  logic           done_q, done_d;
  logic           err_q, err_d;
  logic [WCW-1:0] words_q, words_d;
  logic [AW-1:0]  ea_q, ea_d;
  logic [DW-1:0]  reg_q, reg_d;
  logic [DW-1:0]  mem_q, mem_d;

  vmem_size_chk #(.NBYTES(NBYTES)) u_chk (
    .size_i      (size_bytes),
    .elem_log2_i (elem_log2),
    .half_i      (half_sel),
    .legal_o     (legal),
    .words_o     (words_c)
  );

  always_comb swap_in = is_store ? reg_in : mem_in;

  vmem_swap #(.NBYTES(NBYTES)) u_swap (
    .data_i      (swap_in),
    .big_i       (big_endian),
    .elem_log2_i (elem_log2),
    .size_i      (size_bytes),
    .data_o      (swap_out)
  );

  vmem_ea #(.AW(AW)) u_ea (
    .base_i (base),
    .imm_i  (imm),
    .up_i   (up),
    .big_i  (big_endian),
    .half_i (half_sel),
    .ea_o   (ea_c)
  );

  always_comb begin
    done_d  = start;
    err_d   = start && !legal;
    words_d = words_q;
    ea_d    = ea_q;
    reg_d   = reg_q;
    mem_d   = mem_q;
    if (start && legal) begin
      words_d = words_c;
      ea_d    = ea_c;
      if (is_store) mem_d = swap_out;
      else          reg_d = swap_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      words_q <= '0;
      ea_q    <= '0;
      reg_q   <= '0;
      mem_q   <= '0;
    end else begin
      done_q  <= done_d;
      err_q   <= err_d;
      words_q <= words_d;
      ea_q    <= ea_d;
      reg_q   <= reg_d;
      mem_q   <= mem_d;
    end
  end

  assign done     = done_q;
  assign err      = err_q;
  assign word_cnt = words_q;
  assign ea       = ea_q;
  assign reg_out  = reg_q;
  assign mem_out  = mem_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done_q);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done_q);

  // R4
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q);

  // R4
  hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> ($stable(reg_q) && $stable(mem_q) && $stable(ea_q) && $stable(words_q)));
endmodule

// File: tb/vmem_fmt_bench.sv
module vmem_fmt_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, is_store, big_endian, up;
  logic [1:0]   elem_log2, half_sel;
  logic [4:0]   size_bytes;
  logic [31:0]  base, imm;
  logic [127:0] mem_in, reg_in;
  logic         done, err;
  logic [2:0]   word_cnt;
  logic [31:0]  ea;
  logic [127:0] reg_out, mem_out;

  int checks = 0;
  int errors = 0;

  logic [127:0] exp_reg = '0, exp_mem = '0;
  logic [31:0]  exp_ea = '0;
  logic [2:0]   exp_words = '0;

  always #4 clk = ~clk;

  vmem_fmt u_vmem_fmt (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .big_endian(big_endian), .elem_log2(elem_log2), .size_bytes(size_bytes),
    .half_sel(half_sel), .up(up), .base(base), .imm(imm),
    .mem_in(mem_in), .reg_in(reg_in), .done(done), .err(err),
    .word_cnt(word_cnt), .ea(ea), .reg_out(reg_out), .mem_out(mem_out)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal_req(logic [4:0] sz, logic [1:0] el, logic [1:0] hs);
    int eb = 1 << el;
    bit s_ok = (sz == 1 || sz == 2 || sz == 3 || sz == 4 || sz == 6 ||
                sz == 8 || sz == 12 || sz == 16);
    return s_ok && (int'(sz) % eb == 0) && (hs != 2'd3);
  endfunction

  function automatic logic [127:0] reorder(logic [127:0] d, bit be, logic [1:0] el, logic [4:0] sz);
    logic [127:0] r = '0;
    int eb = 1 << el;
    for (int e = 0; e < int'(sz); e += eb) begin
      for (int j = 0; j < eb; j++) begin
        int dst = be ? (e + eb - 1 - j) : (e + j);
        r[8*dst +: 8] = d[8*(e+j) +: 8];
      end
    end
    return r;
  endfunction

  task automatic run_op(string req, bit st, bit be, logic [1:0] el, logic [4:0] sz,
                        logic [1:0] hs, bit u, logic [31:0] b, logic [31:0] im,
                        logic [127:0] din);
    bit ok = legal_req(sz, el, hs);
    @(negedge clk);
    start = 1'b1; is_store = st; big_endian = be; elem_log2 = el;
    size_bytes = sz; half_sel = hs; up = u; base = b; imm = im;
    if (st) begin reg_in = din; mem_in = ~din; end
    else    begin mem_in = din; reg_in = ~din; end
    if (ok) begin
      exp_words = 3'((int'(sz) + 3) / 4);
      exp_ea = (u ? b + im : b - im);
      if (be && hs == 2'd1) exp_ea = exp_ea + 32'd4;
      if (be && hs == 2'd2) exp_ea = exp_ea - 32'd4;
      if (st) exp_mem = reorder(din, be, el, sz);
      else    exp_reg = reorder(din, be, el, sz);
    end
    @(negedge clk);
    start = 1'b0;
    chk({req, " done"}, 128'(done), 128'(1));
    chk({req, " err"}, 128'(err), 128'(!ok));
    chk({req, " word_cnt"}, 128'(word_cnt), 128'(exp_words));
    chk({req, " ea"}, 128'(ea), 128'(exp_ea));
    chk({req, " reg_out"}, reg_out, exp_reg);
    chk({req, " mem_out"}, mem_out, exp_mem);
  endtask

  localparam logic [127:0] PAT = 128'hF0E0D0C0_B0A09080_70605040_30201000 | 128'h0F0E0D0C_0B0A0908_07060504_03020100;

  task automatic t_reset;
    chk("R11 reset done", 128'(done), 128'(0));
    chk("R11 reset reg_out", reg_out, '0);
    chk("R11 reset mem_out", mem_out, '0);
    chk("R11 reset ea", 128'(ea), '0);
  endtask

  task automatic t_le_load;
    run_op("R6 LE load 16B", 0, 0, 2'd0, 5'd16, 2'd0, 1, 32'h1000, 32'h20, PAT);
    chk("R6 word0", 128'(reg_out[31:0]), 128'(32'h33221100));
    @(negedge clk);
    chk("R11 done drops", 128'(done), 128'(0));
  endtask

  task automatic t_be_elems;
    run_op("R7 BE elem2 8B", 0, 1, 2'd1, 5'd8, 2'd0, 1, 32'h200, 32'h8, PAT);
    run_op("R7 BE elem4 12B", 0, 1, 2'd2, 5'd12, 2'd0, 0, 32'h200, 32'h8, PAT);
    chk("R7 elem4 word0", 128'(reg_out[31:0]), 128'(32'h00112233));
    run_op("R7 BE elem8 16B", 0, 1, 2'd3, 5'd16, 2'd0, 1, 32'h0, 32'h0, PAT);
    run_op("R7 BE elem1 16B", 0, 1, 2'd0, 5'd16, 2'd0, 1, 32'h0, 32'h4, PAT);
  endtask

  task automatic t_mask;
    run_op("R8 mask 3B", 0, 1, 2'd0, 5'd3, 2'd0, 1, 32'h40, 32'h4, PAT);
    chk("R8 3B word0", 128'(reg_out[31:0]), 128'(32'h00221100));
    chk("R5 3B words", 128'(word_cnt), 128'(1));
    run_op("R8 mask 6B", 0, 1, 2'd1, 5'd6, 2'd0, 1, 32'h40, 32'h4, PAT);
    chk("R8 6B word1", 128'(reg_out[63:32]), 128'(32'h00004455));
    run_op("R5 1B", 0, 0, 2'd0, 5'd1, 2'd0, 1, 32'h40, 32'h4, PAT);
  endtask

  task automatic t_store;
    run_op("R9 store BE elem4 4B", 1, 1, 2'd2, 5'd4, 2'd0, 1, 32'h80, 32'h10, PAT);
    chk("R9 store mem word0", 128'(mem_out[31:0]), 128'(32'h00112233));
    run_op("R9 store LE 16B", 1, 0, 2'd3, 5'd16, 2'd0, 0, 32'h80, 32'h10, ~PAT);
  endtask

  task automatic t_illegal;
    run_op("R1 size5", 0, 0, 2'd0, 5'd5, 2'd0, 1, 32'h9, 32'h9, ~PAT);
    run_op("R1 size0", 1, 0, 2'd0, 5'd0, 2'd0, 1, 32'h9, 32'h9, ~PAT);
    run_op("R2 elem4 in 6B", 0, 1, 2'd2, 5'd6, 2'd0, 1, 32'h9, 32'h9, ~PAT);
    run_op("R2 elem8 in 4B", 1, 1, 2'd3, 5'd4, 2'd0, 1, 32'h9, 32'h9, ~PAT);
    run_op("R3 half code3", 0, 1, 2'd2, 5'd8, 2'd3, 1, 32'h9, 32'h9, ~PAT);
    chk("R4 held reg", reg_out, exp_reg);
  endtask

  task automatic t_ea;
    run_op("R10 BE half add", 0, 1, 2'd2, 5'd4, 2'd1, 1, 32'h1000, 32'h10, PAT);
    chk("R10 ea add4", 128'(ea), 128'(32'h1014));
    run_op("R10 BE half sub", 0, 1, 2'd2, 5'd4, 2'd2, 0, 32'h1000, 32'h10, PAT);
    chk("R10 ea sub4", 128'(ea), 128'(32'h0FEC));
    run_op("R10 LE half none", 0, 0, 2'd2, 5'd4, 2'd1, 1, 32'h1000, 32'h10, PAT);
    chk("R10 ea LE", 128'(ea), 128'(32'h1010));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; is_store = 1'b0; big_endian = 1'b0; up = 1'b0;
    elem_log2 = '0; half_sel = '0; size_bytes = '0; base = '0; imm = '0;
    mem_in = '0; reg_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_le_load();
    t_be_elems();
    t_mask();
    t_store();
    t_illegal();
    t_ea();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule